// File: doc/BRIEF.md
# Complex Baseband RMS Gain Regulator

The block sits at the tail of a receive filter chain. It takes one complex sample (I and Q) per valid strobe and measures the signal's mean power with a first-order recursive average. At the end of every averaging interval it compares a logarithmic estimate of the power after scaling with a programmable target. It then moves a gain word toward the value that closes the gap. The loop spans 96 dB in steps of 1/16 octave, which is about 0.38 dB.

Each sample is scaled by the gain that is current when the sample is accepted. The scaled value is rounded and clipped to one of four output resolutions, and a flag marks any sample that had to saturate. The target level, the time constant, the loop shift and the resolution are static configuration inputs. A design with several independent channels places one instance per channel.

Top module: `agc_rms`

## Requirements
- R1: While rst_ni is low, out_valid_o, clip_o, out_i_o, out_q_o and gain_o are all zero. The gain word restarts at 0, which is unity gain.
- R2: A sample accepted at a rising edge with in_valid_i high appears at the second rising edge after it, with out_valid_o high for one cycle. Samples keep their order, and out_valid_o is low whenever no sample was accepted two edges earlier.
- R3: On every accepted sample the power average A becomes A + floor((I*I + Q*Q - A) / 2^tc_i), starting from 0. An averaging interval is 2^tc_i accepted samples.
- R4: The level estimate of A is 16*m + f, where m is the index of the most significant set bit of A and f is the four bits directly below that bit (zero-filled when m < 4). The estimate is 0 for A = 0. The loop error is E = target_i - estimate - 2*G, where G is the gain word.
- R5: At the edge after the one that accepts the last sample of an interval, G becomes G + floor(E / 2^loop_shift_i). E is formed from the average that includes that last sample. G changes at no other time. A sample uses the G held at the edge that accepts it.
- R6: The linear gain is (16 + G mod 16) / 16 * 2^floor(G/16). With res_sel_i = 0 the output is round(x * gain), rounding halves toward plus infinity, on a 16-bit signed scale.
- R7: res_sel_i = s drops 2*s more low bits with the same rounding. The output width becomes W = OW - 2*s, sign-extended on out_i_o/out_q_o.
- R8: A rounded value above 2^(W-1)-1 or below -2^(W-1) is replaced by that limit. clip_o is high in the output cycle of any sample whose I or Q saturated, and low otherwise.
- R9: G is clamped to the range 0 to 256, where 256 is 16 octaves or about 96.3 dB. A negative result gives 0 and a result above 256 gives 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_i_i | input | IW | In-phase sample, signed |
| in_q_i | input | IW | Quadrature sample, signed |
| target_i | input | LW | Requested level, log2 power in 1/16 steps |
| tc_i | input | 4 | Averaging shift and interval exponent |
| loop_shift_i | input | 3 | Loop-gain right shift |
| res_sel_i | input | 2 | Output resolution select |
| out_valid_o | output | 1 | Output sample strobe |
| out_i_o | output | OW | Scaled in-phase output, signed |
| out_q_o | output | OW | Scaled quadrature output, signed |
| clip_o | output | 1 | Saturation flag for the current output |
| gain_o | output | GW | Gain word in 1/16 octave |

## Verification
The bench uses the defaults IW = 16, OW = 16 and GAIN_OCT = 16, so LW = 9 and GW = 9. With these values, full-scale inputs of -32768 reach the top of the 32-bit power word. A one-shot update with a zero shift can drive the gain word into its 256 ceiling, and a zero target pins it at the floor. The four resolution codes bring outputs from 16 bits down to 10 bits within reach, and a unit input at maximum gain overflows the 10-bit range. Phases run with a one-sample interval and with intervals of up to 16 samples, and the valid strobe ranges from dense to sparse.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;
  localparam int FRAC_W = 4;   // fractional bits of log and gain words
  localparam int TC_W   = 4;
  localparam int LS_W   = 3;
  localparam int SEL_W  = 2;

  typedef logic [TC_W-1:0]  tc_t;
  typedef logic [LS_W-1:0]  ls_t;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/agc_power_avg.sv
`timescale 1ns/1ps
module agc_power_avg
  import agc_pkg::*;
#(
  parameter  int IW = 16,
  localparam int PW = 2 * IW,
  localparam int AW = PW + 1,
  localparam int CW = 1 << TC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [IW-1:0] in_i_i,
  input  logic [IW-1:0] in_q_i,
  input  tc_t           tc_i,
  output logic [AW-1:0] avg_o,
  output logic          upd_o
);
  logic [PW-1:0]        sq_i, sq_q, pwr;
  logic [AW-1:0]        avg_q;
  logic signed [AW-1:0] diff, step, nxt;
  logic [CW-1:0]        cnt_q, lim;
  logic                 last, upd_q;

  always_comb begin
    // low PW bits of a sign-extended square are exact
    sq_i = {{IW{in_i_i[IW-1]}}, in_i_i} * {{IW{in_i_i[IW-1]}}, in_i_i};
    sq_q = {{IW{in_q_i[IW-1]}}, in_q_i} * {{IW{in_q_i[IW-1]}}, in_q_i};
    pwr  = sq_i + sq_q;
    diff = {1'b0, pwr} - avg_q;
    step = diff >>> tc_i;
    nxt  = avg_q + step;
    lim  = (CW'(1) << tc_i) - CW'(1);
    last = (cnt_q >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q <= '0;
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= in_valid_i & last;
      if (in_valid_i) begin
        avg_q <= nxt;
        cnt_q <= last ? '0 : cnt_q + CW'(1);
      end
    end
  end

  assign avg_o = avg_q;
  assign upd_o = upd_q;

  // R3: an interval closes only on an accepted sample
  assert_upd_after_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> $past(in_valid_i));
endmodule

// File: rtl/agc_gain_loop.sv
`timescale 1ns/1ps
module agc_gain_loop
  import agc_pkg::*;
#(
  parameter  int AW   = 33,
  parameter  int LW   = 9,
  parameter  int GMAX = 256,
  parameter  int GW   = 9,
  localparam int EW   = LW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [AW-1:0] avg_i,
  input  logic [LW-1:0] target_i,
  input  ls_t           ls_i,
  output logic [GW-1:0] gain_o
);
  function automatic logic [LW-1:0] log_est(input logic [AW-1:0] x);
    int                  m;
    logic [AW-1:0]       nrm;
    logic [FRAC_W-1:0]   fr;
    m = 0;
    for (int b = 0; b < AW; b++) if (x[b]) m = b;
    nrm = x << (AW - 1 - m);
    fr  = FRAC_W'(nrm >> (AW - 1 - FRAC_W));
    return LW'(m * (1 << FRAC_W)) + LW'(fr);
  endfunction

  logic [LW-1:0]        lg;
  logic signed [EW-1:0] err, delta;
  logic signed [EW:0]   gsum;
  logic [GW-1:0]        gain_q, gain_nxt;

  always_comb begin
    lg    = log_est(avg_i);
    err   = $signed(EW'(target_i)) - $signed(EW'(lg)) - $signed(EW'({gain_q, 1'b0}));
    delta = err >>> ls_i;
    gsum  = $signed({1'b0, EW'(gain_q)}) + $signed({delta[EW-1], delta});
    if (gsum[EW])                                gain_nxt = '0;
    else if (gsum > $signed((EW+1)'(GMAX)))      gain_nxt = GW'(GMAX);
    else                                         gain_nxt = gsum[GW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gain_q <= '0;
    else if (upd_i) gain_q <= gain_nxt;
  end

  assign gain_o = gain_q;

  assert_gain_ceiling_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_q <= GW'(GMAX));
  assert_gain_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(gain_q));
endmodule

// File: rtl/agc_scaler.sv
`timescale 1ns/1ps
module agc_scaler
  import agc_pkg::*;
#(
  parameter  int IW       = 16,
  parameter  int OW       = 16,
  parameter  int GW       = 9,
  parameter  int GAIN_OCT = 16,
  localparam int XW       = GW - FRAC_W,
  localparam int PRW      = IW + FRAC_W + 2,
  localparam int FW       = PRW + GAIN_OCT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [IW-1:0] in_i_i,
  input  logic [IW-1:0] in_q_i,
  input  logic [GW-1:0] gain_i,
  input  sel_t          sel_i,
  output logic          out_valid_o,
  output logic [OW-1:0] out_i_o,
  output logic [OW-1:0] out_q_o,
  output logic          clip_o
);
  logic [FRAC_W:0]        mant;
  logic signed [IW-1:0]   smp [2];
  logic signed [PRW-1:0]  prod_q [2];
  logic [XW-1:0]          e_q;
  sel_t                   sel_q;
  logic                   a_v_q, b_v_q, clip_q;
  logic [OW-1:0]          res_q [2];
  logic [OW-1:0]          lane_res [2];
  logic [1:0]             lane_clip;

  assign mant   = {1'b1, gain_i[FRAC_W-1:0]};
  assign smp[0] = $signed(in_i_i);
  assign smp[1] = $signed(in_q_i);

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic signed [FW-1:0] full, half, rnd, hi, lo;
    logic [OW-1:0]        res;
    logic                 clp;
    int                   sh;
    always_comb begin
      sh   = FRAC_W + 2 * int'(sel_q);
      full = FW'(prod_q[k]);
      full = full <<< e_q;
      half = FW'(1) << (sh - 1);
      rnd  = (full + half) >>> sh;
      hi   = (FW'(1) << (OW - 1 - 2 * int'(sel_q))) - FW'(1);
      lo   = -hi - FW'(1);
      clp  = 1'b0;
      if (rnd > hi) begin
        res = OW'(hi);
        clp = 1'b1;
      end else if (rnd < lo) begin
        res = OW'(lo);
        clp = 1'b1;
      end else begin
        res = OW'(rnd);
      end
    end
    assign lane_res[k]  = res;
    assign lane_clip[k] = clp;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_v_q  <= 1'b0;
      b_v_q  <= 1'b0;
      clip_q <= 1'b0;
      e_q    <= '0;
      sel_q  <= '0;
      for (int k = 0; k < 2; k++) begin
        prod_q[k] <= '0;
        res_q[k]  <= '0;
      end
    end else begin
      a_v_q  <= in_valid_i;
      b_v_q  <= a_v_q;
      clip_q <= a_v_q & (|lane_clip);
      if (in_valid_i) begin
        e_q   <= gain_i[GW-1:FRAC_W];
        sel_q <= sel_i;
        for (int k = 0; k < 2; k++)
          prod_q[k] <= PRW'(smp[k]) * PRW'($signed({1'b0, mant}));
      end
      if (a_v_q) begin
        for (int k = 0; k < 2; k++) res_q[k] <= lane_res[k];
      end
    end
  end

  assign out_valid_o = b_v_q;
  assign out_i_o     = res_q[0];
  assign out_q_o     = res_q[1];
  assign clip_o      = clip_q;

  // R8: saturation is only reported alongside a delivered sample
  assert_clip_with_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clip_q |-> b_v_q);
endmodule

// File: rtl/agc_rms.sv
`timescale 1ns/1ps
module agc_rms
  import agc_pkg::*;
#(
  parameter  int IW       = 16,
  parameter  int OW       = 16,
  parameter  int GAIN_OCT = 16,
  localparam int PW       = 2 * IW,
  localparam int AW       = PW + 1,
  localparam int LW       = $clog2(PW) + FRAC_W,
  localparam int GMAX     = GAIN_OCT << FRAC_W,
  localparam int GW       = $clog2(GMAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [IW-1:0] in_i_i,
  input  logic [IW-1:0] in_q_i,
  input  logic [LW-1:0] target_i,
  input  logic [3:0]    tc_i,
  input  logic [2:0]    loop_shift_i,
  input  logic [1:0]    res_sel_i,
  output logic          out_valid_o,
  output logic [OW-1:0] out_i_o,
  output logic [OW-1:0] out_q_o,
  output logic          clip_o,
  output logic [GW-1:0] gain_o
);
  logic [AW-1:0] avg;
  logic          upd;
  logic [GW-1:0] gain;

  agc_power_avg #(.IW(IW)) u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_i_i     (in_i_i),
    .in_q_i     (in_q_i),
    .tc_i       (tc_t'(tc_i)),
    .avg_o      (avg),
    .upd_o      (upd)
  );

  agc_gain_loop #(.AW(AW), .LW(LW), .GMAX(GMAX), .GW(GW)) u_loop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .avg_i    (avg),
    .target_i (target_i),
    .ls_i     (ls_t'(loop_shift_i)),
    .gain_o   (gain)
  );

  agc_scaler #(.IW(IW), .OW(OW), .GW(GW), .GAIN_OCT(GAIN_OCT)) u_scale (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_i_i      (in_i_i),
    .in_q_i      (in_q_i),
    .gain_i      (gain),
    .sel_i       (sel_t'(res_sel_i)),
    .out_valid_o (out_valid_o),
    .out_i_o     (out_i_o),
    .out_q_o     (out_q_o),
    .clip_o      (clip_o)
  );

  assign gain_o = gain;

  assert_out_follows_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##2 out_valid_o);
  assert_no_spurious_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 !out_valid_o);
endmodule

// File: tb/tb_agc_rms.sv
`timescale 1ns/1ps
module tb_agc_rms;
  localparam int IW = 16, OW = 16, GAIN_OCT = 16;
  localparam int LW = 9, GW = 9, GMAX = 256;

  logic          clk_i = 1'b0, rst_ni = 1'b0, in_valid_i = 1'b0;
  logic [IW-1:0] in_i_i = '0, in_q_i = '0;
  logic [LW-1:0] target_i = '0;
  logic [3:0]    tc_i = '0;
  logic [2:0]    loop_shift_i = '0;
  logic [1:0]    res_sel_i = '0;
  logic          out_valid_o, clip_o;
  logic [OW-1:0] out_i_o, out_q_o;
  logic [GW-1:0] gain_o;

  always #2.5 clk_i = ~clk_i;

  agc_rms #(.IW(IW), .OW(OW), .GAIN_OCT(GAIN_OCT)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int cfg_tgt, cfg_tc, cfg_ls, cfg_sel;
  string gain_tag;

  longint m_avg;
  int     m_cnt, m_gain;
  bit     m_upd, pv, ev, pc, ec;
  int     p_i, p_q, e_i, e_q;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_log(longint x);
    int m = -1;
    int fr;
    for (int b = 0; b < 40; b++) if ((x >> b) != 0) m = b;
    if (m < 0) return 0;
    if (m >= 4) fr = int'((x >> (m - 4)) & 15);
    else        fr = int'((x << (4 - m)) & 15);
    return 16 * m + fr;
  endfunction

  task automatic ref_scale(int x, int g, int sel, output int y, output bit c);
    longint v, r, hi, lo;
    int sh, w;
    v  = longint'(x) * longint'(16 + g % 16) * (longint'(1) << (g / 16));
    sh = 4 + 2 * sel;
    r  = (v + (longint'(1) << (sh - 1))) >>> sh;
    w  = OW - 2 * sel;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    c  = 1'b0;
    if (r > hi)      begin r = hi; c = 1'b1; end
    else if (r < lo) begin r = lo; c = 1'b1; end
    y = int'(r);
  endtask

  task automatic advance(bit v, int xi, int xq);
    int g0, y, yq, e, ng;
    bit c, cq;
    longint p;
    g0 = m_gain;
    ev = pv;
    ec = pv ? pc : 1'b0;
    if (pv) begin e_i = p_i; e_q = p_q; end
    pv = v;
    if (v) begin
      ref_scale(xi, g0, cfg_sel, y, c);
      ref_scale(xq, g0, cfg_sel, yq, cq);
      p_i = y; p_q = yq; pc = c | cq;
    end
    if (m_upd) begin
      e  = cfg_tgt - ref_log(m_avg) - 2 * g0;
      ng = g0 + (e >>> cfg_ls);
      if (ng < 0) ng = 0;
      if (ng > GMAX) ng = GMAX;
      m_gain = ng;
    end
    m_upd = v && (m_cnt == (1 << cfg_tc) - 1);
    if (v) begin
      p = longint'(xi) * xi + longint'(xq) * xq;
      m_avg = m_avg + ((p - m_avg) >>> cfg_tc);
      m_cnt = (m_cnt == (1 << cfg_tc) - 1) ? 0 : m_cnt + 1;
    end
  endtask

  task automatic check_outputs();
    chk(out_valid_o === ev, "R2 out_valid", longint'(out_valid_o), longint'(ev));
    chk(int'(gain_o) == m_gain, gain_tag, longint'(gain_o), longint'(m_gain));
    if (ev) begin
      chk(int'($signed(out_i_o)) == e_i, cfg_sel == 0 ? "R6 I" : "R7 I",
          longint'($signed(out_i_o)), longint'(e_i));
      chk(int'($signed(out_q_o)) == e_q, cfg_sel == 0 ? "R6 Q" : "R7 Q",
          longint'($signed(out_q_o)), longint'(e_q));
    end
    chk(clip_o === ec, "R8 clip", longint'(clip_o), longint'(ec));
  endtask

  task automatic cycle(bit v, int xi, int xq);
    @(negedge clk_i);
    check_outputs();
    in_valid_i = v;
    in_i_i = IW'(xi);
    in_q_i = IW'(xq);
    advance(v, xi, xq);
  endtask

  function automatic int rnd_amp(int amp, bit ext);
    int a;
    if (ext && $urandom_range(0, 31) == 0) return $urandom_range(0, 1) ? 32767 : -32768;
    a = (1 << amp) - 1;
    return int'($urandom_range(0, 2 * a)) - a;
  endfunction

  task automatic run_phase(int tgt, int tc, int ls, int sel, int amp, bit ext,
                           int pct, int n, string tag);
    @(negedge clk_i);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    // R1: reset state
    chk(out_valid_o === 1'b0 && clip_o === 1'b0, "R1 flags", longint'({out_valid_o, clip_o}), 0);
    chk(out_i_o === '0 && out_q_o === '0, "R1 data", longint'({out_i_o, out_q_o}), 0);
    chk(gain_o === '0, "R1 gain", longint'(gain_o), 0);
    cfg_tgt = tgt; cfg_tc = tc; cfg_ls = ls; cfg_sel = sel; gain_tag = tag;
    target_i = LW'(tgt); tc_i = 4'(tc); loop_shift_i = 3'(ls); res_sel_i = 2'(sel);
    m_avg = 0; m_cnt = 0; m_gain = 0; m_upd = 0;
    pv = 0; ev = 0; pc = 0; ec = 0; p_i = 0; p_q = 0; e_i = 0; e_q = 0;
    rst_ni = 1'b1;
    for (int i = 0; i < n; i++) begin
      bit v = ($urandom_range(0, 99) < pct);
      cycle(v, rnd_amp(amp, ext), rnd_amp(amp, ext));
    end
    repeat (3) cycle(1'b0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_a6c1));
    // moderate loop, full resolution
    run_phase(300, 2, 1, 0, 8, 1'b1, 70, 2500, "R3/R4/R5 gain");
    // high target drives 16-bit clipping
    run_phase(480, 3, 2, 0, 10, 1'b1, 60, 2500, "R3/R4/R5 gain");
    // reduced resolution, longer interval
    run_phase(400, 4, 1, 2, 6, 1'b0, 80, 2500, "R3/R4/R5 gain");
    // tiny input, zero shift: gain hits its ceiling, 10-bit output clips
    run_phase(511, 1, 0, 3, 1, 1'b0, 50, 2000, "R9 gain ceiling");
    // loud input, zero target: gain stays on its floor
    run_phase(0, 2, 0, 0, 14, 1'b1, 90, 1500, "R9 gain floor");
    // one-sample interval, dense strobe
    run_phase(350, 0, 3, 1, 9, 1'b1, 100, 2000, "R3/R4/R5 gain");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule